// File: doc/BRIEF.md
# Threshold-Flag FIFO with Parity

This block is a single-clock first-in first-out buffer whose write port copies the behaviour of an embedded memory FIFO. A write is requested by pulling two active-low inputs low together: a write enable and a block select. Their OR forms an internal strobe. The word on the data input is stored when that strobe returns high, which is the end of its low phase. After reset the write port is disarmed. It accepts nothing until the write enable has been seen falling once. Any write attempt made while the buffer is full is dropped.

Four registered status flags come out of the block. Two of them report empty and full. The other two compare the occupancy with a threshold input: one for an equal match and one for greater-or-equal. A parity-mode input picks one of two behaviours. In generate mode the block computes an even parity bit for each word and stores it, and the error output stays low. In check mode the block stores the parity bit supplied with the data and reports whether that bit matches the data. The read side is a one-cycle pop pulse. The popped word and its parity bit appear on the following cycle.

Top module: `thr_fifo`

## Requirements
- R1: While reset is high, the outputs settle to empty=1, full=0, at_thresh=0, ge_thresh=0, wr_par_err=0 and rd_data=0 with rd_par=0.
- R2: The write strobe is wr_en_n OR blk_sel_n. A word is stored only when this strobe was low on one clock edge and is high on the next. If only one of the two inputs goes low, nothing is stored.
- R3: After reset, a strobe rise is ignored until wr_en_n has been sampled high on one edge and low on the next. An enable held low through reset therefore does not arm the port.
- R4: While full is high, a write is dropped. The stored words, their order and the occupancy stay unchanged.
- R5: A one-cycle rd_pop pulse while the FIFO is not empty removes the oldest word. That word and its stored parity bit appear on rd_data/rd_par one cycle later, and the words come out in write order.
- R6: empty is high exactly when the occupancy is 0, and full is high exactly when the occupancy equals DEPTH. Both are valid on the edge after the operation that changes the occupancy.
- R7: at_thresh is high when the occupancy equals thresh, and ge_thresh is high when the occupancy is greater than or equal to thresh. Both are recomputed on every clock edge.
- R8: With par_gen=1, the stored parity bit is the XOR of all data bits (even parity), and wr_par_err is 0 one cycle later.
- R9: With par_gen=0, the supplied wr_par_in is stored. One cycle later, wr_par_err equals XOR(wr_data) XOR wr_par_in.
- R10: A read and a write that fire on the same edge while the FIFO is full perform the read, drop the write, and leave the occupancy at DEPTH-1.
- R11: rd_pop while the FIFO is empty has no effect. rd_data/rd_par keep their previous value and empty stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_n | input | 1 | Active-low write enable; its falling edge arms the port |
| blk_sel_n | input | 1 | Active-low block select |
| wr_data | input | DW | Write data |
| wr_par_in | input | 1 | Supplied parity bit (check mode) |
| par_gen | input | 1 | 1 = generate parity, 0 = check supplied parity |
| rd_pop | input | 1 | Pop one word |
| thresh | input | CW | Occupancy threshold |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| at_thresh | output | 1 | Occupancy equals thresh |
| ge_thresh | output | 1 | Occupancy at or above thresh |
| wr_par_err | output | 1 | Parity mismatch on the incoming data (check mode) |
| rd_data | output | DW | Popped word |
| rd_par | output | 1 | Stored parity bit of the popped word |

## Verification
The write fires on the first edge that sees the strobe high after a low edge. Every flag, and the popped word, is registered on that same edge. So each result is due one clock after the firing edge, and the bench samples it on the falling edge that follows. Parity error tracks whatever data and parity bit are on the inputs at each edge, so the bench holds those inputs steady across the rise and samples one cycle later. Threshold changes without any traffic are checked after one idle edge.

// File: rtl/thr_fifo_pkg.sv
package thr_fifo_pkg;
  typedef enum logic {
    PM_CHECK = 1'b0,
    PM_GEN   = 1'b1
  } par_mode_e;

  typedef struct packed {
    logic empty;
    logic full;
    logic at_th;
    logic ge_th;
  } flag_set_t;
endpackage

// File: rtl/thr_fifo_wrport.sv
module thr_fifo_wrport (
  input  logic clk,
  input  logic rst,
  input  logic wr_en_n,
  input  logic blk_sel_n,
  input  logic full,
  output logic wr_fire
);
  logic strobe_n;
  logic strb_q;
  logic wen_q;
  logic armed_q;
  logic rise;

  assign strobe_n = wr_en_n | blk_sel_n;
  assign rise     = !strb_q && strobe_n;
  assign wr_fire  = armed_q && rise && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q  <= 1'b1;
      wen_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      strb_q <= strobe_n;
      wen_q  <= wr_en_n;
      if (wen_q && !wr_en_n) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/thr_fifo_par.sv
module thr_fifo_par
  import thr_fifo_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_par_in,
  input  logic          par_gen,
  output logic          store_bit,
  output logic          wr_par_err
);
  par_mode_e mode;
  logic      calc;

  assign mode      = par_mode_e'(par_gen);
  assign calc      = ^wr_data;
  assign store_bit = (mode == PM_GEN) ? calc : wr_par_in;

  always_ff @(posedge clk) begin
    if (rst) wr_par_err <= 1'b0;
    else     wr_par_err <= (mode == PM_CHECK) && (calc ^ wr_par_in);
  end
endmodule

// File: rtl/thr_fifo_ram.sv
module thr_fifo_ram #(
  parameter int WW    = 9,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/thr_fifo_occ.sv
module thr_fifo_occ
  import thr_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_fire,
  input  logic          rd_pop,
  input  logic [CW-1:0] thresh,
  output logic          rd_fire,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output flag_set_t     flags
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] wnext, rnext;

  assign rd_fire = rd_pop && !flags.empty;
  assign cnt_d   = cnt_q + CW'(wr_fire) - CW'(rd_fire);

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wnext = wptr + AW'(1);
      assign rnext = rptr + AW'(1);
    end else begin : g_wrap
      assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      wptr  <= '0;
      rptr  <= '0;
      flags <= '{empty: 1'b1, full: 1'b0, at_th: 1'b0, ge_th: 1'b0};
    end else begin
      cnt_q       <= cnt_d;
      if (wr_fire) wptr <= wnext;
      if (rd_fire) rptr <= rnext;
      flags.empty <= (cnt_d == '0);
      flags.full  <= (cnt_d == CW'(DEPTH));
      flags.at_th <= (cnt_d == thresh);
      flags.ge_th <= (cnt_d >= thresh);
    end
  end
endmodule

// File: rtl/thr_fifo.sv
module thr_fifo
  import thr_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_n,
  input  logic          blk_sel_n,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_par_in,
  input  logic          par_gen,
  input  logic          rd_pop,
  input  logic [CW-1:0] thresh,
  output logic          empty,
  output logic          full,
  output logic          at_thresh,
  output logic          ge_thresh,
  output logic          wr_par_err,
  output logic [DW-1:0] rd_data,
  output logic          rd_par
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WW = DW + 1;

  logic          wr_fire;
  logic          rd_fire;
  logic          store_bit;
  logic [AW-1:0] wptr, rptr;
  logic [WW-1:0] rword;
  flag_set_t     flags;

  thr_fifo_wrport u_wrport (
    .clk       (clk),
    .rst       (rst),
    .wr_en_n   (wr_en_n),
    .blk_sel_n (blk_sel_n),
    .full      (flags.full),
    .wr_fire   (wr_fire)
  );

  thr_fifo_par #(.DW(DW)) u_par (
    .clk        (clk),
    .rst        (rst),
    .wr_data    (wr_data),
    .wr_par_in  (wr_par_in),
    .par_gen    (par_gen),
    .store_bit  (store_bit),
    .wr_par_err (wr_par_err)
  );

  thr_fifo_occ #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_occ (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (wr_fire),
    .rd_pop  (rd_pop),
    .thresh  (thresh),
    .rd_fire (rd_fire),
    .wptr    (wptr),
    .rptr    (rptr),
    .flags   (flags)
  );

  thr_fifo_ram #(.WW(WW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_fire),
    .waddr (wptr),
    .wdata ({store_bit, wr_data}),
    .re    (rd_fire),
    .raddr (rptr),
    .rdata (rword)
  );

  assign empty     = flags.empty;
  assign full      = flags.full;
  assign at_thresh = flags.at_th;
  assign ge_thresh = flags.ge_th;
  assign rd_data   = rword[DW-1:0];
  assign rd_par    = rword[DW];
endmodule

// File: rtl/thr_fifo_chk.sv
module thr_fifo_chk (
  input logic clk,
  input logic rst,
  input logic rd_pop,
  input logic par_gen,
  input logic wr_fire,
  input logic empty,
  input logic full,
  input logic at_thresh,
  input logic ge_thresh,
  input logic wr_par_err
);
  a_r6_not_both: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  a_r7_eq_in_ge: assert property (@(posedge clk) disable iff (rst)
    at_thresh |-> ge_thresh);

  a_r8_gen_no_err: assert property (@(posedge clk) disable iff (rst)
    par_gen |=> !wr_par_err);

  a_r4_full_holds: assert property (@(posedge clk) disable iff (rst)
    full && !rd_pop |=> full);

  a_r10_read_wins: assert property (@(posedge clk) disable iff (rst)
    full && rd_pop |=> !full);

  a_r11_empty_holds: assert property (@(posedge clk) disable iff (rst)
    empty && !wr_fire |=> empty);
endmodule

bind thr_fifo thr_fifo_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_pop     (rd_pop),
  .par_gen    (par_gen),
  .wr_fire    (wr_fire),
  .empty      (empty),
  .full       (full),
  .at_thresh  (at_thresh),
  .ge_thresh  (ge_thresh),
  .wr_par_err (wr_par_err)
);

// File: tb/sim_thr_fifo.sv
`timescale 1ns/1ps
module sim_thr_fifo;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en_n = 1'b1;
  logic          blk_sel_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic          wr_par_in = 1'b0;
  logic          par_gen = 1'b1;
  logic          rd_pop = 1'b0;
  logic [CW-1:0] thresh = '0;
  logic          empty, full, at_thresh, ge_thresh, wr_par_err, rd_par;
  logic [DW-1:0] rd_data;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  logic [DW:0] q[$];
  logic [DW:0] last_rd = '0;

  always #2.5 clk = ~clk;

  thr_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .blk_sel_n(blk_sel_n),
    .wr_data(wr_data), .wr_par_in(wr_par_in), .par_gen(par_gen),
    .rd_pop(rd_pop), .thresh(thresh), .empty(empty), .full(full),
    .at_thresh(at_thresh), .ge_thresh(ge_thresh), .wr_par_err(wr_par_err),
    .rd_data(rd_data), .rd_par(rd_par)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(input int n, input int th);
    return {n == 0, n == DEPTH, n == th, n >= th};
  endfunction

  task automatic chk_flags(input string req);
    logic [3:0] e, a;
    e = exp_flags(q.size(), int'(thresh));
    a = {empty, full, at_thresh, ge_thresh};
    chk(a == e, req, 32'(a), 32'(e));
  endtask

  // write with optional same-edge read; all results due one cycle after the rise edge
  task automatic do_write(input logic [DW-1:0] d, input logic p, input logic pg,
                          input bit with_rd, input string req);
    bit full_b, rd_ok;
    logic eb;
    @(negedge clk);
    wr_data = d; wr_par_in = p; par_gen = pg;
    wr_en_n = 1'b0; blk_sel_n = 1'b0;
    @(negedge clk);
    wr_en_n = 1'b1; blk_sel_n = 1'b1; rd_pop = with_rd;
    full_b = (q.size() == DEPTH);
    rd_ok  = with_rd && (q.size() > 0);
    @(negedge clk);
    rd_pop = 1'b0;
    if (rd_ok) last_rd = q.pop_front();
    if (!full_b) q.push_back({pg ? ^d : p, d});
    chk_flags(req);
    eb = pg ? 1'b0 : (^d ^ p);
    chk(wr_par_err == eb, pg ? "R8 err low" : "R9 err", 32'(wr_par_err), 32'(eb));
    if (with_rd)
      chk({rd_par, rd_data} == last_rd, "R5 rd word", 32'({rd_par, rd_data}), 32'(last_rd));
  endtask

  task automatic do_read(input string req);
    @(negedge clk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    if (q.size() > 0) last_rd = q.pop_front();
    chk({rd_par, rd_data} == last_rd, req, 32'({rd_par, rd_data}), 32'(last_rd));
    chk_flags(req);
  endtask

  initial begin
    void'($urandom(32'd7031));
    // R1: reset with enable and select held low
    wr_en_n = 1'b0; blk_sel_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({empty, full, at_thresh, ge_thresh, wr_par_err} == 5'b10000, "R1 flags",
        32'({empty, full, at_thresh, ge_thresh, wr_par_err}), 32'h10);
    chk({rd_par, rd_data} == '0, "R1 rd_data", 32'({rd_par, rd_data}), 0);
    rst = 1'b0;
    @(negedge clk);
    // R3: rise without a prior falling edge of wr_en_n is ignored
    wr_en_n = 1'b1; blk_sel_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(empty == 1'b1, "R3 disarmed", 32'(empty), 1);

    // R2: select alone low, then enable alone low (arms) -> nothing stored
    blk_sel_n = 1'b0;
    @(negedge clk); blk_sel_n = 1'b1;
    @(negedge clk); wr_en_n = 1'b0;
    @(negedge clk); wr_en_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(empty == 1'b1, "R2 single input", 32'(empty), 1);

    // R7 directed: threshold 2
    thresh = CW'(2);
    do_write(8'h3C, 1'b0, 1'b1, 0, "R2 first write");
    chk(at_thresh == 1'b0 && ge_thresh == 1'b0, "R7 below", 32'({at_thresh, ge_thresh}), 0);
    do_write(8'h01, 1'b0, 1'b1, 0, "R7 equal");
    chk(at_thresh && ge_thresh, "R7 equal", 32'({at_thresh, ge_thresh}), 3);
    do_write(8'hA5, 1'b0, 1'b1, 0, "R7 above");
    chk(!at_thresh && ge_thresh, "R7 above", 32'({at_thresh, ge_thresh}), 1);

    // R9: check mode, bad and good parity
    do_write(8'h07, 1'b0, 1'b0, 0, "R9 bad parity");
    do_write(8'h07, 1'b1, 1'b0, 0, "R9 good parity");

    // fill to full (R6), extra write dropped (R4), read wins (R10)
    while (q.size() < DEPTH) do_write(8'(q.size() * 17), 1'b0, 1'b1, 0, "R6 fill");
    chk(full == 1'b1, "R6 full", 32'(full), 1);
    do_write(8'hEE, 1'b1, 1'b0, 0, "R4 full drop");
    do_write(8'hDD, 1'b0, 1'b1, 1, "R10 read wins");
    chk(q.size() == DEPTH - 1 && !full, "R10 count", 32'(full), 0);

    // drain all in order (R5, R8 via stored parity), then empty reads (R11)
    while (q.size() > 0) do_read("R5 drain");
    do_read("R11 empty read");
    do_read("R11 empty read again");

    // R7 threshold change with no traffic
    @(negedge clk); thresh = '0;
    @(negedge clk);
    chk(at_thresh && ge_thresh, "R7 th zero", 32'({at_thresh, ge_thresh}), 3);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 3)
        do_write(8'($urandom), 1'($urandom), 1'b1, 0, "R8 rand write");
      else if (op <= 6)
        do_read("R5 rand read");
      else if (op == 7)
        do_write(8'($urandom), 1'($urandom), 1'($urandom), 1, "R10 rand both");
      else if (op == 8) begin
        @(negedge clk); thresh = CW'($urandom_range(0, DEPTH + 2));
        @(negedge clk); chk_flags("R7 rand th");
      end else
        do_write(8'($urandom), 1'($urandom), 1'b0, 0, "R9 rand check");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule